// File: doc/BRIEF.md
# Configurable FIFO Address Counter

This block keeps the write and read positions of a FIFO that is built from one or more identical RAM blocks. Each RAM block can be set to one of several depth-by-width shapes, and blocks can be cascaded to make a deeper FIFO. The block takes two static mode codes: the log2 of the per-block word width and the log2 of the cascade count. From these it produces, for each port, a 12-bit in-block RAM address and a block-select field.

Address bits 11..5 are used in every mode. Each halving of the word width brings one more low-order bit below bit 5 into use, so the lowest active bit index equals the width code. Each doubling of the cascade count brings one more bit above bit 11 into use, and those upper bits pick the RAM block. Both counters carry a hidden wrap bit just above the highest active bit, so the block can tell a full FIFO from an empty one. A write moves the write counter only when the FIFO is not full. A read moves the read counter only when the FIFO is not empty. The mode is taken in only while `clr` is high.

Top module: `fifo_addr_counter`

## Requirements
- R1: A clock edge with `clr` high sets both counters to zero, which is the empty state. All address and block-select outputs then read 0 from the next cycle.
- R2: `wsel` and `csel` are captured only on edges where `clr` is high. Changing them while `clr` is low has no effect on the step size or the wrap point.
- R3: Each accepted access adds 2^W to its address, where W is the captured width code (0 = 1-bit words to 5 = 32-bit words). Address bits below bit W are always 0.
- R4: The block-select output is the counter field above bit 11. Only its low C bits can be nonzero, where C is the captured cascade code (0..4 meaning 1, 2, 4, 8 or 16 blocks).
- R5: The FIFO depth is 2^(12-W+C) words. With that many words stored, a write alone leaves the write address and block select unchanged.
- R6: With no words stored, a read leaves the read address and block select unchanged.
- R7: After one full depth of accepted accesses, a port's address and block select return to 0.
- R8: When both enables are high, only the write advances if the FIFO was empty, and only the read advances if it was full. Otherwise both advance.
- R9: A width code above 5 is captured as 5. A cascade code above 4 is captured as 4.
- R10: With four cascaded blocks of 4-bit words (W=2, C=2), the 1024th write leaves the in-block address at 0 and the block select at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous active-high clear; also captures the mode codes |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| wsel | input | 3 | log2 of the per-block word width (0..5) |
| csel | input | 3 | log2 of the number of cascaded blocks (0..4) |
| wr_addr | output | 12 | In-block RAM address for the write port |
| wr_blk | output | 4 | Block select for the write port |
| rd_addr | output | 12 | In-block RAM address for the read port |
| rd_blk | output | 4 | Block select for the read port |

## Verification
A wrong step size or a wrongly captured mode shows on the address outputs one cycle after the first accepted access, as nonzero bits below the active range or as a wrong increment. A faulty wrap bit or faulty full/empty decision stays hidden until the FIFO reaches a boundary. It then shows up as an address that moves when it should hold, or that holds when it should move, on the very next edge. A block-select fault appears only when a counter carries past bit 11, so each mode is driven through at least one carry and one full wrap.

// File: rtl/fifo_addr_counter.sv
module fifo_addr_counter #(
  parameter int BLK_MSB  = 11,
  parameter int MAX_WSEL = 5,
  parameter int MAX_CSEL = 4,
  parameter int WSEL_W   = 3,
  parameter int CSEL_W   = 3
) (
  input  logic                 clk,
  input  logic                 clr,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [WSEL_W-1:0]    wsel,
  input  logic [CSEL_W-1:0]    csel,
  output logic [BLK_MSB:0]     wr_addr,
  output logic [MAX_CSEL-1:0]  wr_blk,
  output logic [BLK_MSB:0]     rd_addr,
  output logic [MAX_CSEL-1:0]  rd_blk
);
  localparam int ADDR_W = BLK_MSB + 1;
  localparam int BLK_W  = MAX_CSEL;
  localparam int PTR_W  = ADDR_W + MAX_CSEL + 1;

  logic [WSEL_W-1:0] lo_q;
  logic [CSEL_W-1:0] cs_q;
  logic [PTR_W-1:0]  wp, rp;
  logic [PTR_W-1:0]  step, span, wrap_bit;
  logic [BLK_W-1:0]  blk_mask;
  logic              full, empty, do_wr, do_rd;

  assign step     = PTR_W'(1) << lo_q;
  assign span     = ~({PTR_W{1'b1}} << (ADDR_W + 1 + 32'(cs_q)));
  assign wrap_bit = PTR_W'(1) << (ADDR_W + 32'(cs_q));
  assign blk_mask = ~({BLK_W{1'b1}} << cs_q);

  assign empty = (wp == rp);
  assign full  = ((wp ^ rp) == wrap_bit);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (clr) begin
      lo_q <= (32'(wsel) > MAX_WSEL) ? WSEL_W'(MAX_WSEL) : wsel;
      cs_q <= (32'(csel) > MAX_CSEL) ? CSEL_W'(MAX_CSEL) : csel;
      wp   <= '0;
      rp   <= '0;
    end else begin
      if (do_wr) wp <= (wp + step) & span;
      if (do_rd) rp <= (rp + step) & span;
    end
  end

  assign wr_addr = wp[ADDR_W-1:0];
  assign rd_addr = rp[ADDR_W-1:0];
  assign wr_blk  = wp[ADDR_W +: BLK_W] & blk_mask;
  assign rd_blk  = rp[ADDR_W +: BLK_W] & blk_mask;
endmodule

// File: rtl/fifo_addr_counter_chk.sv
module fifo_addr_counter_chk #(
  parameter int ADDR_W = 12,
  parameter int BLK_W  = 4,
  parameter int WSEL_W = 3,
  parameter int CSEL_W = 3
) (
  input logic              clk,
  input logic              clr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BLK_W-1:0]  wr_blk,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [BLK_W-1:0]  rd_blk,
  input logic [WSEL_W-1:0] lo,
  input logic [CSEL_W-1:0] cs,
  input logic              full,
  input logic              empty
);
  p_clr_empty_r1: assert property (@(posedge clk)
    clr |=> (wr_addr == '0 && rd_addr == '0 && wr_blk == '0 && rd_blk == '0));

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (clr)
    1'b1 |=> ($stable(lo) && $stable(cs)));

  p_low_zero_r3: assert property (@(posedge clk) disable iff (clr)
    ((wr_addr & ~({ADDR_W{1'b1}} << lo)) == '0) && ((rd_addr & ~({ADDR_W{1'b1}} << lo)) == '0));

  p_blk_range_r4: assert property (@(posedge clk) disable iff (clr)
    ((wr_blk & ({BLK_W{1'b1}} << cs)) == '0) && ((rd_blk & ({BLK_W{1'b1}} << cs)) == '0));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (clr)
    (full && wr_en) |=> ($stable(wr_addr) && $stable(wr_blk)));

  p_no_underflow_r6: assert property (@(posedge clk) disable iff (clr)
    (empty && rd_en) |=> ($stable(rd_addr) && $stable(rd_blk)));

  p_flags_exclusive_r5: assert property (@(posedge clk) disable iff (clr)
    !(full && empty));
endmodule

bind fifo_addr_counter fifo_addr_counter_chk #(
  .ADDR_W(BLK_MSB + 1), .BLK_W(MAX_CSEL), .WSEL_W(WSEL_W), .CSEL_W(CSEL_W)
) u_chk (
  .clk(clk), .clr(clr), .wr_en(wr_en), .rd_en(rd_en),
  .wr_addr(wr_addr), .wr_blk(wr_blk), .rd_addr(rd_addr), .rd_blk(rd_blk),
  .lo(lo_q), .cs(cs_q), .full(full), .empty(empty)
);

// File: tb/test_fifo_addr_counter.sv
module test_fifo_addr_counter;
  localparam int PERIOD = 10;

  logic clk = 1'b0, clr = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] wsel = 3'd5, csel = 3'd0;
  logic [11:0] wr_addr, rd_addr;
  logic [3:0]  wr_blk, rd_blk;

  int checks = 0, errors = 0;
  int mw, mc, wt, rt;

  always #(PERIOD/2) clk = ~clk;

  fifo_addr_counter i_fifo_addr_counter (
    .clk(clk), .clr(clr), .wr_en(wr_en), .rd_en(rd_en), .wsel(wsel), .csel(csel),
    .wr_addr(wr_addr), .wr_blk(wr_blk), .rd_addr(rd_addr), .rd_blk(rd_blk)
  );

  function automatic int depth();
    return 1 << (12 - mw + mc);
  endfunction

  function automatic int pos_of(int n);
    return ((n % (2 * depth())) % depth()) << mw;
  endfunction

  task automatic check_ports(string tag);
    int wpos, rpos;
    wpos = pos_of(wt);
    rpos = pos_of(rt);
    checks++;
    if (wr_addr !== 12'(wpos) || wr_blk !== 4'(wpos >> 12) ||
        rd_addr !== 12'(rpos) || rd_blk !== 4'(rpos >> 12)) begin
      errors++;
      $display("FAIL %s: wr=%0d/%0d rd=%0d/%0d expected wr=%0d/%0d rd=%0d/%0d", tag,
               wr_blk, wr_addr, rd_blk, rd_addr,
               wpos >> 12, wpos & 12'hfff, rpos >> 12, rpos & 12'hfff);
    end
  endtask

  task automatic do_clear(int w, int c);
    @(negedge clk);
    wsel = 3'(w); csel = 3'(c); clr = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    @(negedge clk);
    clr = 1'b0;
    mw = (w > 5) ? 5 : w;
    mc = (c > 4) ? 4 : c;
    wt = 0; rt = 0;
    check_ports("R1 clear");
  endtask

  task automatic cycle(bit we, bit re, string tag);
    int occ;
    occ = wt - rt;
    wr_en = we; rd_en = re;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    if (we && occ < depth()) wt++;
    if (re && occ > 0) rt++;
    check_ports(tag);
  endtask

  task automatic t_small_fill_drain();
    do_clear(5, 0);
    for (int i = 0; i < 5; i++) cycle(1, 0, "R3 step 32");
    for (int i = 5; i < 128; i++) cycle(1, 0, "R5 fill");
    cycle(1, 0, "R5 write while full");
    cycle(1, 0, "R5 write while full");
    for (int i = 0; i < 128; i++) cycle(0, 1, "R7 drain");
    cycle(0, 1, "R6 read while empty");
    for (int i = 0; i < 128; i++) cycle(1, 0, "R7 second lap");
  endtask

  task automatic t_mode_static();
    do_clear(5, 0);
    @(negedge clk);
    wsel = 3'd0; csel = 3'd4;
    cycle(1, 0, "R2 mode change ignored");
    cycle(1, 0, "R2 mode change ignored");
    for (int i = 2; i < 128; i++) cycle(1, 0, "R2 depth kept");
    cycle(1, 0, "R2 full at old depth");
  endtask

  task automatic t_two_blocks();
    do_clear(5, 1);
    for (int i = 0; i < 130; i++) cycle(1, 0, "R4 block select carry");
    for (int i = 0; i < 130; i++) cycle(0, 1, "R4 read block select");
  endtask

  task automatic t_four_by_four();
    do_clear(2, 2);
    for (int i = 0; i < 1024; i++) cycle(1, 0, "R10 in-block sweep");
    checks++;
    if (wr_addr !== 12'd0 || wr_blk !== 4'd1) begin
      errors++;
      $display("FAIL R10: addr=%0d blk=%0d expected addr=0 blk=1", wr_addr, wr_blk);
    end
    cycle(1, 0, "R3 step 4");
  endtask

  task automatic t_simultaneous();
    do_clear(5, 0);
    cycle(1, 1, "R8 both while empty");
    cycle(1, 1, "R8 both mid");
    cycle(1, 1, "R8 both mid");
    for (int i = 1; i < 128; i++) cycle(1, 0, "R8 fill");
    cycle(1, 1, "R8 both while full");
    cycle(1, 1, "R8 both after full");
  endtask

  task automatic t_clamp();
    do_clear(7, 7);
    cycle(1, 0, "R9 width clamp");
    for (int i = 1; i < 130; i++) cycle(1, 0, "R9 cascade clamp");
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    mw = 5; mc = 0; wt = 0; rt = 0;
    repeat (2) @(negedge clk);
    t_small_fill_drain();
    t_mode_static();
    t_two_blocks();
    t_four_by_four();
    t_simultaneous();
    t_clamp();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule